// File: doc/BRIEF.md
# Transmit Collision Retry Controller

This block manages the retry sequence of a half-duplex CSMA/CD transmitter. It holds the transmit enable flag, which software sets. When the flag is set and the transmit queue has a packet at its head, the block captures that packet's number and asks the data mover to start feeding it to the MAC. From then on it follows the MAC's collision and completion pulses. A collision below the retry limit fires the backoff timer and tells the data mover that a collision happened. Once the timer's done pulse comes back, the block asks for the packet to be fed again from its first byte.

When the collision that reaches the limit arrives, the block gives up on the packet. It pushes the packet number into the completion queue, raises an excessive-collision flag for one cycle and clears the transmit enable. While the enable stays clear, the whole queue stalls: no later packet starts until software sets the enable again. A successful transmission also pushes the packet number, this time with a success flag, and leaves the enable set, so the next queued packet starts on its own.

The backoff delay, the MAC framing and buffer allocation are handled elsewhere. The reset `rst_n` is asynchronous and active low, and it is expected to be released in step with `clk`.

Top module: `txretry_ctrl`

## Requirements
- R1: While reset is held and after it is released, tx_enable, start_req, backoff_trig, col_ind, cq_push, excess_flag and success_flag are all 0.
- R2: A one-cycle pulse on sw_en_set sets tx_enable from the next cycle. If the block is idle, tx_enable is 1 and pkt_avail is 1, then start_req pulses for exactly one cycle, one cycle later.
- R3: Suppose a collision pulse arrives during an attempt and fewer than MAX_TRIES-1 collisions have already hit the same packet. Then, in the next cycle, backoff_trig and col_ind pulse together for one cycle, and nothing is pushed to the completion queue.
- R4: After a normal collision, start_req pulses only in the cycle after backoff_done is sampled. There is never a start_req without such a pulse or an idle start condition.
- R5: The MAX_TRIES-th collision on one packet (16 with the default) leads, one cycle later, to cq_push and excess_flag pulsing together, with cq_pnum holding the packet number. In that same cycle tx_enable falls to 0, and backoff_trig stays 0.
- R6: While tx_enable is 0 after giving up, no start_req is issued, even with pkt_avail held at 1. The next start follows only after sw_en_set.
- R7: A done pulse during an attempt leads, one cycle later, to cq_push and success_flag together, and tx_enable stays 1. If pkt_avail is 1, the next packet's start_req follows one cycle after that.
- R8: The retry count restarts at zero for every new packet. A packet always gets the full MAX_TRIES attempts, whatever collisions earlier packets had.
- R9: Collision and done pulses have no effect outside an attempt (while idle or waiting for backoff), and backoff_done has no effect outside the backoff wait. In each case no output pulse follows.
- R10: If sw_en_set arrives in the same cycle as the collision that gives up, tx_enable stays 1, and the next queued packet starts.
- R11: cq_pnum carries the value pkt_num had in the cycle that caused that packet's first start, even if pkt_num changes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en_set | input | 1 | Software pulse that sets the transmit enable |
| pkt_avail | input | 1 | Transmit queue holds a packet at its head |
| pkt_num | input | PNUM_W | Packet number at the queue head |
| col_pulse | input | 1 | MAC collision pulse |
| done_pulse | input | 1 | MAC transmission-complete pulse |
| backoff_done | input | 1 | Backoff timer expiry pulse |
| tx_enable | output | 1 | Transmit enable flag |
| start_req | output | 1 | Request to the data mover to feed the packet from its start |
| backoff_trig | output | 1 | Starts the backoff timer |
| col_ind | output | 1 | Tells the data mover a collision happened |
| cq_push | output | 1 | Push into the completion queue (also pops the transmit queue) |
| cq_pnum | output | PNUM_W | Packet number being pushed |
| excess_flag | output | 1 | One-cycle flag: packet abandoned after too many collisions |
| success_flag | output | 1 | One-cycle flag: packet sent successfully |

## Verification
The bench builds the block with its defaults: MAX_TRIES of 16 and a 6-bit packet number. With those values the retry limit is exercised at its true size. One packet goes through fifteen backoff rounds and then gives up on the sixteenth collision. Because that packet comes right after another packet that had collisions of its own, a retry count that is not cleared between packets would give up too early, so the test also checks the per-packet reset of the count. The 6-bit number lets the bench change pkt_num in the middle of an attempt and confirm that the captured value is the one reported.

// File: rtl/txretry_pkg.sv
package txretry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_BACKOFF = 2'd2
  } tr_state_e;
endpackage

// File: rtl/txretry_cnt.sv
// Per-packet collision counter; flags when the next collision is the last allowed.
module txretry_cnt #(
  parameter int MAX_TRIES = 16,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_try
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_try = (cnt_q == CNT_W'(MAX_TRIES - 1));
endmodule

// File: rtl/txretry_enable.sv
// Transmit enable flag: software set wins over a hardware clear.
module txretry_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic hw_clr,
  output logic en
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (hw_clr) en_d = 1'b0;
    if (sw_set) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/txretry_fsm.sv
// Attempt sequencer: start, collision/backoff loop, completion push.
module txretry_fsm
  import txretry_pkg::*;
#(
  parameter int PNUM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              pkt_avail,
  input  logic [PNUM_W-1:0] pkt_num,
  input  logic              col_pulse,
  input  logic              done_pulse,
  input  logic              backoff_done,
  input  logic              last_try,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              hw_clr,
  output logic              start_req,
  output logic              backoff_trig,
  output logic              cq_push,
  output logic [PNUM_W-1:0] cq_pnum,
  output logic              excess_flag,
  output logic              success_flag
);
  tr_state_e         state_q, state_d;
  logic              start_q, start_d;
  logic              bo_q, bo_d;
  logic              push_q, push_d;
  logic              xs_q, xs_d;
  logic              ok_q, ok_d;
  logic              pnum_ld;
  logic [PNUM_W-1:0] pnum_q;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    bo_d    = 1'b0;
    push_d  = 1'b0;
    xs_d    = 1'b0;
    ok_d    = 1'b0;
    pnum_ld = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    hw_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_en && pkt_avail) begin
          start_d = 1'b1;
          pnum_ld = 1'b1;
          cnt_clr = 1'b1;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (col_pulse) begin
          if (last_try) begin
            push_d  = 1'b1;
            xs_d    = 1'b1;
            hw_clr  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            bo_d    = 1'b1;
            cnt_inc = 1'b1;
            state_d = ST_BACKOFF;
          end
        end else if (done_pulse) begin
          push_d  = 1'b1;
          ok_d    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_BACKOFF: begin
        if (backoff_done) begin
          start_d = 1'b1;
          state_d = ST_SEND;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      bo_q    <= 1'b0;
      push_q  <= 1'b0;
      xs_q    <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      bo_q    <= bo_d;
      push_q  <= push_d;
      xs_q    <= xs_d;
      ok_q    <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pnum_q <= '0;
    else if (pnum_ld) pnum_q <= pkt_num;
  end

  assign start_req    = start_q;
  assign backoff_trig = bo_q;
  assign cq_push      = push_q;
  assign cq_pnum      = pnum_q;
  assign excess_flag  = xs_q;
  assign success_flag = ok_q;
endmodule

// File: rtl/txretry_ctrl.sv
module txretry_ctrl #(
  parameter int MAX_TRIES = 16,
  parameter int PNUM_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en_set,
  input  logic              pkt_avail,
  input  logic [PNUM_W-1:0] pkt_num,
  input  logic              col_pulse,
  input  logic              done_pulse,
  input  logic              backoff_done,
  output logic              tx_enable,
  output logic              start_req,
  output logic              backoff_trig,
  output logic              col_ind,
  output logic              cq_push,
  output logic [PNUM_W-1:0] cq_pnum,
  output logic              excess_flag,
  output logic              success_flag
);
  logic cnt_clr, cnt_inc, last_try, hw_clr, bo_int;

  txretry_enable u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_set (sw_en_set),
    .hw_clr (hw_clr),
    .en     (tx_enable)
  );

  txretry_cnt #(.MAX_TRIES(MAX_TRIES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .last_try (last_try)
  );

  txretry_fsm #(.PNUM_W(PNUM_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_enable),
    .pkt_avail    (pkt_avail),
    .pkt_num      (pkt_num),
    .col_pulse    (col_pulse),
    .done_pulse   (done_pulse),
    .backoff_done (backoff_done),
    .last_try     (last_try),
    .cnt_clr      (cnt_clr),
    .cnt_inc      (cnt_inc),
    .hw_clr       (hw_clr),
    .start_req    (start_req),
    .backoff_trig (bo_int),
    .cq_push      (cq_push),
    .cq_pnum      (cq_pnum),
    .excess_flag  (excess_flag),
    .success_flag (success_flag)
  );

  assign backoff_trig = bo_int;
  assign col_ind      = bo_int;
endmodule

// File: rtl/txretry_chk.sv
module txretry_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_en_set,
  input logic pkt_avail,
  input logic col_pulse,
  input logic done_pulse,
  input logic backoff_done,
  input logic tx_enable,
  input logic start_req,
  input logic backoff_trig,
  input logic col_ind,
  input logic cq_push,
  input logic excess_flag,
  input logic success_flag
);
  assert_backoff_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_trig |-> col_ind && $past(col_pulse) && !cq_push);

  assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(backoff_done) || $past(tx_enable && pkt_avail));

  assert_excess_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    excess_flag |-> cq_push && !backoff_trig && !start_req && $past(col_pulse));

  assert_enable_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_enable) |-> excess_flag);

  assert_start_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(tx_enable));

  assert_success_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    success_flag |-> cq_push && $past(done_pulse) && !excess_flag);

  assert_push_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cq_push |-> $countones({success_flag, excess_flag}) == 1);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_en_set) |-> tx_enable);
endmodule

bind txretry_ctrl txretry_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_en_set    (sw_en_set),
  .pkt_avail    (pkt_avail),
  .col_pulse    (col_pulse),
  .done_pulse   (done_pulse),
  .backoff_done (backoff_done),
  .tx_enable    (tx_enable),
  .start_req    (start_req),
  .backoff_trig (backoff_trig),
  .col_ind      (col_ind),
  .cq_push      (cq_push),
  .excess_flag  (excess_flag),
  .success_flag (success_flag)
);

// File: tb/txretry_ctrl_bench.sv
`timescale 1ns/1ps
module txretry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_TRIES  = 16;
  localparam int PNUM_W     = 6;

  localparam logic [1:0] EV_START = 2'd0;
  localparam logic [1:0] EV_BKOFF = 2'd1;
  localparam logic [1:0] EV_OK    = 2'd2;
  localparam logic [1:0] EV_XS    = 2'd3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sw_en_set, pkt_avail, col_pulse, done_pulse, backoff_done;
  logic [PNUM_W-1:0] pkt_num;
  logic              tx_enable, start_req, backoff_trig, col_ind, cq_push;
  logic              excess_flag, success_flag;
  logic [PNUM_W-1:0] cq_pnum;

  int checks = 0;
  int errors = 0;
  bit run_done = 1'b0;

  logic [PNUM_W+1:0] exp_q[$];
  string             tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txretry_ctrl #(.MAX_TRIES(MAX_TRIES), .PNUM_W(PNUM_W)) u_txretry_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_en_set(sw_en_set), .pkt_avail(pkt_avail),
    .pkt_num(pkt_num), .col_pulse(col_pulse), .done_pulse(done_pulse),
    .backoff_done(backoff_done), .tx_enable(tx_enable), .start_req(start_req),
    .backoff_trig(backoff_trig), .col_ind(col_ind), .cq_push(cq_push),
    .cq_pnum(cq_pnum), .excess_flag(excess_flag), .success_flag(success_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_ev(input logic [1:0] kind, input logic [PNUM_W-1:0] pn, input string tag);
    exp_q.push_back({kind, pn});
    tag_q.push_back(tag);
  endtask

  // Monitor: sample outputs at the falling edge and compare with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !run_done) begin
      if (start_req || backoff_trig || cq_push || col_ind) begin
        logic [1:0]        kind;
        logic [PNUM_W-1:0] pn;
        logic [PNUM_W+1:0] got, expv;
        string             t;
        pn = '0;
        if (col_ind !== backoff_trig) begin
          checks++; errors++;
          $display("FAIL R3 col_ind %0d backoff_trig %0d expected equal", col_ind, backoff_trig);
        end
        if (start_req) kind = EV_START;
        else if (backoff_trig) kind = EV_BKOFF;
        else if (excess_flag) begin kind = EV_XS; pn = cq_pnum; end
        else begin kind = EV_OK; pn = cq_pnum; end
        if ($countones({start_req, backoff_trig, cq_push}) != 1 ||
            (cq_push && $countones({excess_flag, success_flag}) != 1)) begin
          checks++; errors++;
          $display("FAIL R7 overlapping outputs actual %b expected one",
                   {start_req, backoff_trig, cq_push, excess_flag, success_flag});
        end
        got = {kind, pn};
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected event actual %0h expected none", got);
        end else begin
          expv = exp_q.pop_front();
          t    = tag_q.pop_front();
          check(got === expv, t, int'(got), int'(expv));
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    tick(1);
    sig = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) tick(1);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // One full non-final retry round: collision, backoff, restart.
  task automatic retry_round(input string tag);
    expect_ev(EV_BKOFF, '0, tag);
    pulse(col_pulse);
    tick(2);
    expect_ev(EV_START, '0, tag);
    pulse(backoff_done);
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sw_en_set = 0; pkt_avail = 0; col_pulse = 0; done_pulse = 0; backoff_done = 0;
    pkt_num = '0;
    tick(3);
    check({tx_enable, start_req, backoff_trig, col_ind, cq_push, excess_flag, success_flag} == 0,
          "R1 in reset", int'(tx_enable), 0);
    rst_n = 1'b1;
    tick(2);
    check({tx_enable, start_req, backoff_trig, col_ind, cq_push, excess_flag, success_flag} == 0,
          "R1 after reset", int'(tx_enable), 0);

    // R9: pulses while idle and disabled do nothing
    pulse(col_pulse); pulse(done_pulse); pulse(backoff_done);
    tick(3);

    // R2: enable then start of packet 5
    pkt_num = 6'd5; pkt_avail = 1'b1;
    expect_ev(EV_START, '0, "R2 first start");
    pulse(sw_en_set);
    check(tx_enable == 1'b1, "R2 enable set", int'(tx_enable), 1);
    tick(2);
    drain("R2 start seen");
    pkt_num = 6'd9;  // R11: changes mid-attempt
    pkt_avail = 1'b0;

    // R3/R4: three collisions; stray pulses in backoff ignored (R9)
    for (int k = 0; k < 3; k++) begin
      expect_ev(EV_BKOFF, '0, "R3 backoff");
      pulse(col_pulse);
      tick(1);
      pulse(col_pulse);   // R9 ignored during backoff
      pulse(done_pulse);  // R9 ignored during backoff
      tick(3);
      expect_ev(EV_START, '0, "R4 restart after backoff");
      pulse(backoff_done);
      tick(2);
      pulse(backoff_done); // R9 ignored during attempt
      tick(2);
    end
    drain("R4 rounds");

    // R7/R11: success of packet 5 with next packet 7 waiting
    pkt_num = 6'd7; pkt_avail = 1'b1;
    expect_ev(EV_OK, 6'd5, "R11 R7 success pnum");
    expect_ev(EV_START, '0, "R7 auto next start");
    pulse(done_pulse);
    check(tx_enable == 1'b1, "R7 enable kept", int'(tx_enable), 1);
    tick(3);
    drain("R7 events");

    // R8: packet 7 gets full MAX_TRIES despite earlier collisions
    for (int k = 0; k < MAX_TRIES - 1; k++) retry_round("R8 retry round");
    drain("R8 rounds");
    expect_ev(EV_XS, 6'd7, "R5 give up pnum");
    pulse(col_pulse);
    check(tx_enable == 1'b0, "R5 enable cleared", int'(tx_enable), 0);
    check(excess_flag == 1'b1, "R5 excess flag", int'(excess_flag), 1);
    tick(1);
    drain("R5 event");

    // R6: queue stalled while disabled
    pkt_num = 6'd12;
    tick(8);
    check(tx_enable == 1'b0, "R6 still disabled", int'(tx_enable), 0);
    expect_ev(EV_START, '0, "R6 restart after set");
    pulse(sw_en_set);
    tick(2);
    drain("R6 start");

    // R10: give-up collision coincides with software set
    for (int k = 0; k < MAX_TRIES - 1; k++) retry_round("R10 retry round");
    drain("R10 rounds");
    pkt_num = 6'd20;
    expect_ev(EV_XS, 6'd12, "R10 give up pnum");
    expect_ev(EV_START, '0, "R10 next start");
    col_pulse = 1'b1; sw_en_set = 1'b1;
    tick(1);
    col_pulse = 1'b0; sw_en_set = 1'b0;
    check(tx_enable == 1'b1, "R10 enable kept", int'(tx_enable), 1);
    tick(2);
    drain("R10 events");

    // R7 with empty queue, then R9 idle pulses
    pkt_avail = 1'b0;
    expect_ev(EV_OK, 6'd20, "R7 success no follow-on");
    pulse(done_pulse);
    tick(3);
    pulse(col_pulse); pulse(done_pulse); pulse(backoff_done);
    tick(4);
    drain("R9 idle quiet");
    check(tx_enable == 1'b1, "R7 enable after success", int'(tx_enable), 1);

    run_done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule